// File: doc/BRIEF.md
# Glitch-Free Programmable Baud Clock Generator

This block makes a square-wave baud clock from a selectable tick source. The source is either every system clock or one of several external strobes that are synchronous to the system clock. An optional divide-by-16 prescaler follows the source, and then a programmable phase counter divides the result. Software controls everything through one 32-bit configuration word on a simple write/read port. The word can be rewritten at any moment, even while logic that uses the baud clock keeps running.

The divider settings (count, prescaler select and source select) are shadowed. A new value reaches the running counter only when the current output period completes, or at once when the generator leaves its reset state. Because of this, the output never shows a shortened pulse. A software reset bit parks the generator with the output high. A separate enable bit freezes all counting without losing position, for low-power use.

The controller is a three-state machine. ST_IDLE is the parked state: the output is high and the counters are clear. ST_HIGH drives the high half of the period and ST_LOW drives the low half. Its transitions are:
- start: ST_IDLE to ST_HIGH, which loads the shadows.
- half: ST_HIGH to ST_LOW, when the high phase ends.
- wrap: ST_LOW to ST_HIGH, which ends the period and loads the shadows.
- solo: ST_HIGH to ST_HIGH, a wrap for a one-tick period that has no low phase.
- park: any state to ST_IDLE, taken while the reset bit is set.

Top module: `bclk_gen`

## Requirements
- R1: After the hardware reset input is released, the output is high, the configuration word reads 0, and the output stays high until software enables the generator.
- R2: Configuration word fields, numbered from LSB = bit 0:
  - [0] prescaler select
  - [12:1] count CD
  - [13] stored-only flag
  - [15:14] source select
  - [16] enable
  - [17] software reset
  
  Bits [31:18] always read 0. A write is visible on the read port in the following cycle.
- R3: The period is N = CD+1 ticks after the prescaler. The output is high for ceil(N/2) ticks and then low for floor(N/2) ticks, starting with the high phase.
- R4: When the prescaler select is 1, one divided tick occurs every 16 source ticks, so every phase lasts 16 times longer.
- R5: Source select 0 counts every system clock. A value k from 1 to 3 counts only cycles in which ext_tick[k-1] is 1, and all other strobes are ignored.
- R6: A change to count, prescaler or source made in the middle of a period does not alter that period. It takes effect from the next period onward.
- R7: When reset is 0 and enable is 1 while the generator is parked, the shadows load immediately. The high phase starts on the clock after the register update, so the first high phase seen from the write lasts ceil(N/2)+1 cycles.
- R8: While the software reset bit is 1, the output is high from the next cycle on and the generator stays parked.
- R9: While enable is 0, the prescaler, the phase counter and the output hold their values. Counting resumes from the same point once enable returns to 1.
- R10: With CD = 0 there is no low phase, so the output stays high while running.
- R11: The stored-only flag reads back as written and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| ext_tick | input | 3 | External tick strobes, synchronous to clk |
| bclk_out | output | 1 | Baud clock output |

## Verification
On every cycle, the embedded properties check these behaviours:
- the register readback one cycle after a write
- the forced-high output under software reset
- the frozen counters and output while enable is low
- the fact that active settings change only on a load
- the phase counter staying inside its limit

Exact phase lengths in cycles need the bench's scenarios. This covers odd and even counts, the prescaler, external strobes beside an ignored one, a rewrite in the middle of a period, a freeze inside a high phase, the start-up latency and the one-tick period.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    localparam int DEF_CD_W    = 12;
    localparam int DEF_N_EXT   = 3;
    localparam int DEF_PRE_DIV = 16;
    localparam int DEF_REG_W   = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } gen_state_e;

endpackage

// File: rtl/bclk_regs.sv
module bclk_regs #(
    parameter int CD_W  = bclk_pkg::DEF_CD_W,
    parameter int SRC_W = 2,
    parameter int REG_W = bclk_pkg::DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             rst_bit,
    output logic             en_bit,
    output logic [SRC_W-1:0] src_sh,
    output logic [CD_W-1:0]  cd_sh,
    output logic             div_sh
);
    localparam int P_DIV = 0;
    localparam int P_CD  = 1;
    localparam int P_ATB = P_CD + CD_W;
    localparam int P_SRC = P_ATB + 1;
    localparam int P_EN  = P_SRC + SRC_W;
    localparam int P_RST = P_EN + 1;
    localparam int USED  = P_RST + 1;

    logic atb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_bit <= 1'b0;
            en_bit  <= 1'b0;
            src_sh  <= '0;
            atb_q   <= 1'b0;
            cd_sh   <= '0;
            div_sh  <= 1'b0;
        end else if (we) begin
            rst_bit <= wdata[P_RST];
            en_bit  <= wdata[P_EN];
            src_sh  <= wdata[P_SRC +: SRC_W];
            atb_q   <= wdata[P_ATB];
            cd_sh   <= wdata[P_CD +: CD_W];
            div_sh  <= wdata[P_DIV];
        end
    end

    always_comb begin
        rdata                = '0;
        rdata[P_RST]         = rst_bit;
        rdata[P_EN]          = en_bit;
        rdata[P_SRC +: SRC_W] = src_sh;
        rdata[P_ATB]         = atb_q;
        rdata[P_CD +: CD_W]  = cd_sh;
        rdata[P_DIV]         = div_sh;
    end

    // R2: a write shows up masked on the read port one cycle later
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & {{(REG_W-USED){1'b0}}, {USED{1'b1}}})));

endmodule

// File: rtl/bclk_tick.sv
module bclk_tick #(
    parameter int N_EXT   = bclk_pkg::DEF_N_EXT,
    parameter int SRC_W   = 2,
    parameter int PRE_DIV = bclk_pkg::DEF_PRE_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SRC_W-1:0] src,
    input  logic             div16,
    input  logic [N_EXT-1:0] ext_tick,
    output logic             dtick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic raw_tick;

    always_comb begin
        raw_tick = (src == '0);
        for (int k = 0; k < N_EXT; k++) begin
            if (src == SRC_W'(k + 1)) raw_tick = ext_tick[k];
        end
    end

    generate
        if (PRE_DIV > 1) begin : g_pre
            logic [PRE_W-1:0] pre_q;
            logic             pre_last;

            assign pre_last = (pre_q == PRE_W'(PRE_DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clear) begin
                    pre_q <= '0;
                end else if (run && raw_tick && div16) begin
                    pre_q <= pre_last ? '0 : pre_q + 1'b1;
                end
            end

            assign dtick = run && raw_tick && (!div16 || pre_last);

            // R9: a stopped generator leaves the prescaler untouched
            p_pre_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !clear) |=> $stable(pre_q));
        end else begin : g_nopre
            assign dtick = run && raw_tick;
        end
    endgenerate

endmodule

// File: rtl/bclk_fsm.sv
module bclk_fsm #(
    parameter int CD_W  = bclk_pkg::DEF_CD_W,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_bit,
    input  logic             en_bit,
    input  logic [SRC_W-1:0] src_sh,
    input  logic [CD_W-1:0]  cd_sh,
    input  logic             div_sh,
    input  logic             dtick,
    output logic             run,
    output logic             clear,
    output logic [SRC_W-1:0] act_src,
    output logic             act_div,
    output logic             bclk
);
    import bclk_pkg::*;

    gen_state_e      state_q, state_n;
    logic [CD_W-1:0] cnt_q, cnt_n;
    logic [CD_W-1:0] act_cd;
    logic [CD_W:0]   hi_sum, lo_sum;
    logic [CD_W-1:0] hi_len, lo_len;
    logic            start, hi_end, lo_end, wrap, load;

    always_comb begin
        hi_sum = {1'b0, act_cd} + (CD_W + 1)'(2);
        lo_sum = {1'b0, act_cd} + (CD_W + 1)'(1);
        hi_len = hi_sum[CD_W:1];
        lo_len = lo_sum[CD_W:1];
    end

    always_comb begin
        run    = (state_q != ST_IDLE) && en_bit && !rst_bit;
        start  = (state_q == ST_IDLE) && en_bit && !rst_bit;
        hi_end = run && dtick && (state_q == ST_HIGH) && (cnt_q == hi_len - 1'b1);
        lo_end = run && dtick && (state_q == ST_LOW) && (cnt_q == lo_len - 1'b1);
        wrap   = lo_end || (hi_end && (lo_len == '0));
        load   = start || wrap;
        clear  = load || (state_q == ST_IDLE);
    end

    always_comb begin
        state_n = state_q;
        if (rst_bit) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_n = ST_HIGH;
                ST_HIGH: if (hi_end) state_n = (lo_len == '0) ? ST_HIGH : ST_LOW;
                ST_LOW:  if (lo_end) state_n = ST_HIGH;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if ((state_n == ST_IDLE) || load || hi_end) begin
            cnt_n = '0;
        end else if (run && dtick) begin
            cnt_n = cnt_q + 1'b1;
        end else begin
            cnt_n = cnt_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
    end

    // active settings, loaded from the shadows only on start or wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cd  <= '0;
            act_div <= 1'b0;
            act_src <= '0;
        end else if (load) begin
            act_cd  <= cd_sh;
            act_div <= div_sh;
            act_src <= src_sh;
        end
    end

    // output register, driven from the next state so it changes with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk <= 1'b1;
        else        bclk <= (state_n != ST_LOW);
    end

    // R8: software reset forces the output high on the next cycle
    p_rst_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_bit |=> bclk);

    // R9: with enable low a running generator freezes output and counter
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && !en_bit && !rst_bit) |=> ($stable(bclk) && $stable(cnt_q)));

    // R6: active settings change only in the cycle after a load
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_cd) || !$stable(act_div) || !$stable(act_src)) |-> $past(load));

    // R3: the high-phase counter never passes its limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> (cnt_q < hi_len));

    // R3: the low-phase counter never passes its limit
    p_cnt_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (cnt_q < lo_len));

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen #(
    parameter int CD_W    = bclk_pkg::DEF_CD_W,
    parameter int N_EXT   = bclk_pkg::DEF_N_EXT,
    parameter int PRE_DIV = bclk_pkg::DEF_PRE_DIV,
    parameter int REG_W   = bclk_pkg::DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [N_EXT-1:0] ext_tick,
    output logic             bclk_out
);
    localparam int SRC_W = $clog2(N_EXT + 1);

    logic             rst_bit, en_bit, div_sh, act_div;
    logic [SRC_W-1:0] src_sh, act_src;
    logic [CD_W-1:0]  cd_sh;
    logic             run, clear, dtick;

    bclk_regs #(.CD_W(CD_W), .SRC_W(SRC_W), .REG_W(REG_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .rst_bit(rst_bit), .en_bit(en_bit), .src_sh(src_sh), .cd_sh(cd_sh), .div_sh(div_sh)
    );

    bclk_tick #(.N_EXT(N_EXT), .SRC_W(SRC_W), .PRE_DIV(PRE_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(clear), .src(act_src),
        .div16(act_div), .ext_tick(ext_tick), .dtick(dtick)
    );

    bclk_fsm #(.CD_W(CD_W), .SRC_W(SRC_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .rst_bit(rst_bit), .en_bit(en_bit), .src_sh(src_sh),
        .cd_sh(cd_sh), .div_sh(div_sh), .dtick(dtick), .run(run), .clear(clear),
        .act_src(act_src), .act_div(act_div), .bclk(bclk_out)
    );

endmodule

// File: tb/bclk_gen_tb_top.sv
module bclk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  ext_tick = '0;
    logic        bclk_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    bclk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_tick(ext_tick), .bclk_out(bclk_out)
    );

    function automatic logic [31:0] mk(bit rst, bit en, bit [1:0] src, bit atb,
                                       bit [11:0] cd, bit div16);
        return {14'b0, rst, en, src, atb, cd, div16};
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [31:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // driver side of the scoreboard: expected run (level, length in cycles)
    task automatic expect_run(bit lvl, int len, string tag);
        exp_q.push_back((int'(lvl) << 16) | len);
        tag_q.push_back(tag);
    endtask

    task automatic launch(bit [11:0] cd, bit div16, bit [1:0] src);
        cfg_write(mk(1, 0, src, 0, cd, div16));
        mon_en = 1'b1;
        cfg_write(mk(0, 1, src, 0, cd, div16));
    endtask

    task automatic drain(string tag);
        int n = 0;
        while (exp_q.size() > 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " scoreboard drained"}, exp_q.size(), 0);
        mon_en = 1'b0;
        exp_q.delete();
        tag_q.delete();
        cfg_write(mk(1, 0, 0, 0, 0, 0));
    endtask

    // monitor: measures each completed level run and compares with the queue
    int run_len  = 0;
    bit prev_lvl = 1'b1;
    bit skip     = 1'b1;
    always @(negedge clk) begin
        if (!mon_en) begin
            run_len = 0;
            skip    = 1'b1;
        end else if (run_len == 0) begin
            run_len  = 1;
            prev_lvl = bclk_out;
        end else if (bclk_out == prev_lvl) begin
            run_len++;
        end else begin
            if (skip) begin
                skip = 1'b0;
            end else if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " level"}, int'(prev_lvl), e >> 16);
                check({t, " run length"}, run_len, e & 16'hFFFF);
            end
            run_len  = 1;
            prev_lvl = bclk_out;
        end
    end

    // external strobes: ext_tick[1] every third cycle, ext_tick[0] always (ignored unless selected)
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            ext_tick = {1'b0, (ph == 0), 1'b1};
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and idle while not enabled
        check("R1 output after reset", int'(bclk_out), 1);
        check("R1 register after reset", int'(cfg_rdata), 0);
        hi_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            hi_cnt += int'(bclk_out);
        end
        check("R1 output stays high while disabled", hi_cnt, 8);

        // R2, R11, R8: readback masking, stored flag, reset holds output high
        cfg_write(32'hFFFF_FFFF);
        check("R2 reserved bits read zero", int'(cfg_rdata), 32'h0003_FFFF);
        check("R11 stored flag readback", int'(cfg_rdata[13]), 1);
        check("R8 output high while reset bit set", int'(bclk_out), 1);
        cfg_write(mk(1, 0, 2, 0, 12'h5A5, 0));
        check("R2 field placement", int'(cfg_rdata), (1 << 17) | (2 << 14) | (12'h5A5 << 1));

        // R3: even period, CD=3 -> 2 high, 2 low
        launch(3, 0, 0);
        expect_run(0, 2, "R3 even"); expect_run(1, 2, "R3 even");
        expect_run(0, 2, "R3 even"); expect_run(1, 2, "R3 even");
        drain("R3 even");

        // R3: odd period, CD=4 -> 3 high, 2 low
        launch(4, 0, 0);
        expect_run(0, 2, "R3 odd"); expect_run(1, 3, "R3 odd");
        expect_run(0, 2, "R3 odd"); expect_run(1, 3, "R3 odd");
        drain("R3 odd");

        // R4: prescaler, CD=1 -> 16 high, 16 low
        launch(1, 1, 0);
        expect_run(0, 16, "R4 prescaler"); expect_run(1, 16, "R4 prescaler");
        expect_run(0, 16, "R4 prescaler");
        drain("R4 prescaler");

        // R5: source 2 uses ext_tick[1] (every 3rd cycle), CD=2 -> 2 ticks high, 1 low
        launch(2, 0, 2);
        expect_run(0, 3, "R5 external source"); expect_run(1, 6, "R5 external source");
        expect_run(0, 3, "R5 external source"); expect_run(1, 6, "R5 external source");
        drain("R5 external source");

        // R6: rewrite CD in a high phase; current period keeps 4/4, then 1/1
        launch(7, 0, 0);
        expect_run(0, 4, "R6 before rewrite");
        expect_run(1, 4, "R6 current period high");
        expect_run(0, 4, "R6 current period low");
        expect_run(1, 1, "R6 new period"); expect_run(0, 1, "R6 new period");
        expect_run(1, 1, "R6 new period"); expect_run(0, 1, "R6 new period");
        @(posedge bclk_out);
        cfg_write(mk(0, 1, 0, 0, 1, 0));
        drain("R6 rewrite");

        // R9: freeze for 12 edges inside a 4-cycle high phase -> 16
        launch(7, 0, 0);
        expect_run(0, 4, "R9 before freeze");
        expect_run(1, 16, "R9 frozen high phase");
        expect_run(0, 4, "R9 after freeze");
        @(posedge bclk_out);
        cfg_write(mk(0, 0, 0, 0, 7, 0));
        repeat (10) @(negedge clk);
        cfg_write(mk(0, 1, 0, 0, 7, 0));
        drain("R9 freeze");

        // R7: start latency with new CD=5 (previous active CD was 7): 3+1 cycles
        cfg_write(mk(1, 0, 0, 0, 5, 0));
        cfg_write(mk(0, 1, 0, 0, 5, 0));
        hi_cnt = 0;
        while (bclk_out && hi_cnt < 100) begin
            @(negedge clk);
            hi_cnt++;
        end
        check("R7 first high phase from write", hi_cnt, 4);

        // R8: software reset in the middle of a low phase
        cfg_write(mk(1, 0, 0, 0, 7, 0));
        cfg_write(mk(0, 1, 0, 0, 7, 0));
        @(negedge bclk_out);
        cfg_write(mk(1, 1, 0, 0, 7, 0));
        @(negedge clk);
        check("R8 output forced high", int'(bclk_out), 1);
        hi_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            hi_cnt += int'(bclk_out);
        end
        check("R8 output held high", hi_cnt, 10);

        // R10 and R11: CD=0 keeps output high, stored flag has no effect
        cfg_write(mk(1, 0, 0, 1, 0, 0));
        cfg_write(mk(0, 1, 0, 1, 0, 0));
        hi_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            hi_cnt += int'(bclk_out);
        end
        check("R10 single-tick period stays high", hi_cnt, 20);

        // R11: stored flag set with CD=3 still gives 2/2
        launch(3, 0, 0);
        cfg_write(mk(0, 1, 0, 1, 3, 0));
        expect_run(0, 2, "R11 flag ignored"); expect_run(1, 2, "R11 flag ignored");
        drain("R11 flag ignored");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule